// File: doc/BRIEF.md
# Configuration Stream Command Sequencer

This block takes a stream of 32-bit configuration words over a valid/ready handshake and steps through the phases of a configuration stream in order. It stays idle until a synchronization word appears. It then expects a device identifier, which must equal a configured value. After that it accepts frame-address and frame-write commands and passes their data words to a frame-write port. The stream is closed by a run of no-operation words and a desync command.

A multi-frame write supplies the data for one frame once. The block forwards that frame and keeps a copy in a local buffer. It then writes the stored frame again for each further copy, and requests a frame-address increment before each replay. While it replays, the input is stalled. The flags for synchronized, accepted, error and done let the surrounding logic follow the outcome.

Top module: `cfg_stream_seq`

## Requirements
- R1: After reset, `synced`, `accepted`, `error`, `done`, `fw_valid`, `fw_inc` and `fw_load` are low and `in_ready` is high.
- R2: While unsynchronized, every word is discarded without any output effect until a word equal to `SYNC_WORD` (default 0xAA995566) is accepted; `synced` is high from the next cycle.
- R3: Bits 31:28 of a command word hold the opcode. Opcode 0x1 compares bits 27:0 with `DEVICE_ID`: on a match `accepted` rises one cycle later, and on a mismatch the block enters the error state.
- R4: Opcode 0x2 produces a one-cycle `fw_load` pulse, with `fw_addr` equal to bits 27:0, in the cycle after acceptance.
- R5: Opcode 0x3 with count N in bits 15:0 forwards the next N accepted words on `fw_data` with `fw_valid`, each one cycle after its acceptance. N = 0 forwards nothing.
- R6: Opcode 0x4 with copy count C in bits 15:0 (0 counts as 1) forwards the next `FRAME_WORDS` accepted words. It then writes the stored frame C-1 more times in the same word order, and each replay is preceded by exactly one `fw_inc` pulse.
- R7: `in_ready` is low for the whole replay phase and high in every other state.
- R8: Opcodes 0x2, 0x3 or 0x4 received before a matching device identifier send the block to the error state.
- R9: Opcode 0x0 is a NOOP. Opcode 0xF (DESYNC) that follows at least `MIN_NOOPS` consecutive NOOPs produces a one-cycle `done` pulse and returns the block to the unsynchronized state with `accepted` cleared. Any other command breaks the NOOP run.
- R10: A DESYNC after fewer than `MIN_NOOPS` consecutive NOOPs, or any opcode not listed above, sends the block to the error state.
- R11: In the error state `error` is high and `accepted` is low, and all words are discarded until a sync word is accepted, which resynchronizes the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input configuration word |
| in_ready | output | 1 | Block can accept a word |
| fw_valid | output | 1 | Frame data word valid |
| fw_data | output | 32 | Frame data word |
| fw_inc | output | 1 | Frame-address increment request |
| fw_load | output | 1 | Load new frame address |
| fw_addr | output | 28 | Frame address for `fw_load` |
| synced | output | 1 | Stream is synchronized |
| accepted | output | 1 | Device identifier matched |
| error | output | 1 | Stream rejected |
| done | output | 1 | Configuration completed pulse |

## Verification
A wrong phase state shows at the ports within one cycle. `synced`, `error` and `in_ready` come straight from the state, and a data word that lands in the wrong phase shows up as a missing or extra `fw_valid` on the next cycle. A wrong replay count or buffer index shows as a misplaced `fw_inc`, a wrong replayed word, or `in_ready` staying low too long or too short. A wrong NOOP count appears at the DESYNC as `error` in place of `done`, or the other way round.

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq #(
  parameter int          FRAME_WORDS = 4,
  parameter int          MIN_NOOPS   = 4,
  parameter logic [27:0] DEVICE_ID   = 28'h0A1B2C3,
  parameter logic [31:0] SYNC_WORD   = 32'hAA995566
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        fw_valid,
  output logic [31:0] fw_data,
  output logic        fw_inc,
  output logic        fw_load,
  output logic [27:0] fw_addr,
  output logic        synced,
  output logic        accepted,
  output logic        error,
  output logic        done
);
  localparam int IW = $clog2(FRAME_WORDS + 1);
  localparam int NW = $clog2(MIN_NOOPS + 1);
  localparam logic [IW-1:0] LAST = IW'(FRAME_WORDS - 1);
  localparam logic [NW-1:0] NMAX = NW'(MIN_NOOPS);

  typedef enum logic [2:0] {S_HUNT, S_CMD, S_DATA, S_LOAD, S_PLAY, S_ERR} st_t;

  st_t            state;
  logic [15:0]    cnt;
  logic [IW-1:0]  idx;
  logic [NW-1:0]  noops;
  logic           gap;
  logic           bad;
  logic [31:0]    frame_mem [FRAME_WORDS];

  wire       take = in_valid && in_ready;
  wire [3:0] op   = in_data[31:28];

  assign in_ready = (state != S_PLAY);
  assign synced   = (state == S_CMD) || (state == S_DATA) || (state == S_LOAD) || (state == S_PLAY);
  assign error    = (state == S_ERR);

  always_comb begin
    bad = 1'b0;
    if (take && state == S_CMD) begin
      case (op)
        4'h0:              bad = 1'b0;
        4'h1:              bad = (in_data[27:0] != DEVICE_ID);
        4'h2, 4'h3, 4'h4:  bad = !accepted;
        4'hF:              bad = (noops != NMAX);
        default:           bad = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take && state == S_LOAD) frame_mem[idx] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_HUNT;
      cnt      <= '0;
      idx      <= '0;
      noops    <= '0;
      gap      <= 1'b0;
      accepted <= 1'b0;
      fw_valid <= 1'b0;
      fw_data  <= '0;
      fw_inc   <= 1'b0;
      fw_load  <= 1'b0;
      fw_addr  <= '0;
      done     <= 1'b0;
    end else begin
      fw_valid <= 1'b0;
      fw_inc   <= 1'b0;
      fw_load  <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_HUNT, S_ERR: begin
          if (take && in_data == SYNC_WORD) begin
            state <= S_CMD;
            noops <= '0;
          end
        end
        S_CMD: begin
          if (bad) begin
            state    <= S_ERR;
            accepted <= 1'b0;
          end else if (take) begin
            noops <= (op == 4'h0) ? ((noops == NMAX) ? noops : noops + 1'b1) : '0;
            case (op)
              4'h1: accepted <= 1'b1;
              4'h2: begin
                fw_load <= 1'b1;
                fw_addr <= in_data[27:0];
              end
              4'h3: begin
                if (in_data[15:0] != 16'd0) begin
                  state <= S_DATA;
                  cnt   <= in_data[15:0];
                end
              end
              4'h4: begin
                state <= S_LOAD;
                idx   <= '0;
                cnt   <= (in_data[15:0] == 16'd0) ? 16'd1 : in_data[15:0];
              end
              4'hF: begin
                done     <= 1'b1;
                state    <= S_HUNT;
                accepted <= 1'b0;
              end
              default: ;
            endcase
          end
        end
        S_DATA: begin
          if (take) begin
            fw_valid <= 1'b1;
            fw_data  <= in_data;
            cnt      <= cnt - 1'b1;
            if (cnt == 16'd1) state <= S_CMD;
          end
        end
        S_LOAD: begin
          if (take) begin
            fw_valid <= 1'b1;
            fw_data  <= in_data;
            idx      <= idx + 1'b1;
            if (idx == LAST) begin
              idx <= '0;
              if (cnt == 16'd1) state <= S_CMD;
              else begin
                state <= S_PLAY;
                cnt   <= cnt - 1'b1;
                gap   <= 1'b1;
              end
            end
          end
        end
        S_PLAY: begin
          if (gap) begin
            fw_inc <= 1'b1;
            gap    <= 1'b0;
          end else begin
            fw_valid <= 1'b1;
            fw_data  <= frame_mem[idx];
            idx      <= idx + 1'b1;
            if (idx == LAST) begin
              idx <= '0;
              if (cnt == 16'd1) state <= S_CMD;
              else begin
                cnt <= cnt - 1'b1;
                gap <= 1'b1;
              end
            end
          end
        end
        default: state <= S_HUNT;
      endcase
    end
  end
endmodule

module cfg_stream_seq_chk #(
  parameter logic [31:0] SYNC_WORD = 32'hAA995566
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        in_ready,
  input logic        fw_valid,
  input logic        fw_inc,
  input logic        fw_load,
  input logic        synced,
  input logic        accepted,
  input logic        error,
  input logic        done
);
  a_r7_stall_on_inc: assert property (@(posedge clk) disable iff (!rst_n)
    fw_inc |-> !in_ready);

  a_r6_inc_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    fw_inc |=> fw_valid);

  a_r11_hold_error: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !(in_valid && in_data == SYNC_WORD)) |=> error);

  a_r11_error_not_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !accepted);

  a_r9_done_unsyncs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!synced && !accepted));

  a_r5_data_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> $past(synced));

  a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fw_valid, fw_inc, fw_load, done}));
endmodule

bind cfg_stream_seq cfg_stream_seq_chk #(.SYNC_WORD(SYNC_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .fw_valid(fw_valid), .fw_inc(fw_inc), .fw_load(fw_load),
  .synced(synced), .accepted(accepted), .error(error), .done(done));

// File: tb/test_cfg_stream_seq.sv
module test_cfg_stream_seq;
  localparam int          FW   = 4;
  localparam int          MINN = 4;
  localparam logic [27:0] DEV  = 28'h0A1B2C3;
  localparam logic [31:0] SYNC = 32'hAA995566;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, fw_valid, fw_inc, fw_load, synced, accepted, error, done;
  logic [31:0] fw_data;
  logic [27:0] fw_addr;

  cfg_stream_seq #(.FRAME_WORDS(FW), .MIN_NOOPS(MINN), .DEVICE_ID(DEV), .SYNC_WORD(SYNC)) i_cfg_stream_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .fw_valid(fw_valid), .fw_data(fw_data), .fw_inc(fw_inc), .fw_load(fw_load),
    .fw_addr(fw_addr), .synced(synced), .accepted(accepted), .error(error), .done(done));

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int done_seen = 0;
  int inc_seen = 0;

  // behavioural reference: 0 hunt, 1 command, 2 data, 3 load, 4 replay, 5 error
  int m_mode, m_rem, m_reps, m_pos, m_noops;
  bit m_id;
  int unsigned m_q[$];
  bit e_fwv, e_inc, e_load, e_done;
  logic [31:0] e_fwd;
  logic [27:0] e_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_reps = 0; m_pos = 0; m_noops = 0; m_id = 0;
      m_q.delete();
      e_fwv = 0; e_inc = 0; e_load = 0; e_done = 0; e_fwd = 0; e_addr = 0;
    end else begin
      bit acc, fail;
      logic [31:0] w;
      int run;
      acc = in_valid && (m_mode != 4);
      w = in_data;
      fail = 0;
      e_fwv = 0; e_inc = 0; e_load = 0; e_done = 0;
      case (m_mode)
        0, 5: if (acc && w == SYNC) begin m_mode = 1; m_noops = 0; end
        1: if (acc) begin
          run = m_noops;
          m_noops = (w[31:28] == 4'h0) ? m_noops + 1 : 0;
          case (w[31:28])
            4'h0: ;
            4'h1: if (w[27:0] == DEV) m_id = 1; else fail = 1;
            4'h2: if (!m_id) fail = 1; else begin e_load = 1; e_addr = w[27:0]; end
            4'h3: if (!m_id) fail = 1; else if (w[15:0] != 0) begin m_mode = 2; m_rem = w[15:0]; end
            4'h4: if (!m_id) fail = 1; else begin
              m_mode = 3; m_q.delete(); m_reps = (w[15:0] == 0) ? 1 : w[15:0];
            end
            4'hF: if (run < MINN) fail = 1; else begin e_done = 1; m_mode = 0; m_id = 0; end
            default: fail = 1;
          endcase
          if (fail) begin m_mode = 5; m_id = 0; end
        end
        2: if (acc) begin
          e_fwv = 1; e_fwd = w; m_rem--;
          if (m_rem == 0) m_mode = 1;
        end
        3: if (acc) begin
          e_fwv = 1; e_fwd = w; m_q.push_back(w);
          if (m_q.size() == FW) begin
            if (m_reps == 1) m_mode = 1;
            else begin m_reps--; m_mode = 4; m_pos = -1; end
          end
        end
        4: begin
          if (m_pos < 0) begin e_inc = 1; m_pos = 0; end
          else begin
            e_fwv = 1; e_fwd = m_q[m_pos]; m_pos++;
            if (m_pos == FW) begin
              if (m_reps == 1) m_mode = 1;
              else begin m_reps--; m_pos = -1; end
            end
          end
        end
        default: m_mode = 0;
      endcase
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R7", "in_ready", 32'(in_ready), 32'(m_mode != 4));
    chk("R2", "synced", 32'(synced), 32'(m_mode >= 1 && m_mode <= 4));
    chk("R11", "error", 32'(error), 32'(m_mode == 5));
    chk("R3", "accepted", 32'(accepted), 32'(m_id));
    chk("R5", "fw_valid", 32'(fw_valid), 32'(e_fwv));
    if (e_fwv) chk("R5", "fw_data", fw_data, e_fwd);
    chk("R6", "fw_inc", 32'(fw_inc), 32'(e_inc));
    chk("R4", "fw_load", 32'(fw_load), 32'(e_load));
    if (e_load) chk("R4", "fw_addr", 32'(fw_addr), 32'(e_addr));
    chk("R9", "done", 32'(done), 32'(e_done));
    if (done) done_seen++;
    if (fw_inc) inc_seen++;
  end

  task automatic send(logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 32'hDEAD_0000 + 32'(i);
    end
  endtask

  task automatic noops(int n);
    for (int i = 0; i < n; i++) send(32'h0000_0000 + 32'(i));
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "in_ready", 32'(in_ready), 1);
    chk("R1", "flags", {28'd0, synced, accepted, error, done}, 0);
    chk("R1", "pulses", {29'd0, fw_valid, fw_inc, fw_load}, 0);
    rst_n = 1'b1;
    idle(2);
    // R2 junk before sync, including command-like words
    send(32'h1000_0000 | 32'(DEV)); send(32'h3000_0002); send(32'hF000_0000); send(32'h1234_5678);
    idle(1);
    chk("R2", "still unsynced", 32'(synced), 0);
    // main stream
    send(SYNC);
    send(32'h1000_0000 | 32'(DEV));
    send(32'h2000_0040);
    send(32'h3000_0003); send(32'hA1A1_0001); idle(2); send(32'hA1A1_0002); send(32'hA1A1_0003);
    send(32'h3000_0000);
    send(32'h2000_0100);
    send(32'h4000_0003); send(32'hB0B0_0001); send(32'hB0B0_0002); idle(1); send(32'hB0B0_0003); send(32'hB0B0_0004);
    noops(MINN);
    send(32'hF000_0000);
    idle(3);
    chk("R6", "inc pulses for 3 copies", inc_seen, 2);
    chk("R9", "done pulses", done_seen, 1);
    // R8 address before ID
    send(SYNC); send(32'h2000_0001); send(32'h1000_0000 | 32'(DEV)); idle(2);
    chk("R8", "error after early address", 32'(error), 1);
    // R11 junk in error, then resync; R3 mismatch
    send(32'h0000_0000); send(SYNC); send(32'h1000_0000 | 32'(DEV ^ 28'h1)); idle(2);
    chk("R3", "error after id mismatch", 32'(error), 1);
    // R10 short NOOP run
    send(SYNC); send(32'h1000_0000 | 32'(DEV)); noops(MINN - 1); send(32'hF000_0000); idle(2);
    chk("R10", "error after short noop run", 32'(error), 1);
    // R10 undefined opcode
    send(SYNC); send(32'h7000_0000); idle(2);
    // R9 run broken by another command; R6 single copy
    send(SYNC); send(32'h1000_0000 | 32'(DEV));
    send(32'h4000_0000); send(32'hC0C0_0001); send(32'hC0C0_0002); send(32'hC0C0_0003); send(32'hC0C0_0004);
    noops(2); send(32'h2000_0777); noops(2); send(32'hF000_0000); idle(2);
    chk("R9", "broken run rejected", 32'(error), 1);
    send(SYNC); send(32'h1000_0000 | 32'(DEV));
    send(32'h4000_0002); send(32'hD0D0_0001); send(32'hD0D0_0002); send(32'hD0D0_0003); send(32'hD0D0_0004);
    send(32'h3000_0001); send(32'hE0E0_0001);
    noops(MINN + 2); send(32'hF000_0000);
    idle(3);
    chk("R9", "done pulses total", done_seen, 2);
    chk("R6", "inc pulses total", inc_seen, 3);
    finish_run();
  end
endmodule